// File: doc/BRIEF.md
# T1 Receive Line Code Decoder

This block turns the received T1 line signal into a single-rail NRZ bit stream and keeps a running count of line code violations. Two input forms are accepted. One is a dual-rail pair of positive and negative pulse indications, qualified once per bit. The other is a single serial input, qualified once per bit for plain NRZ or once per half-bit for CMI (1T2B). Three configuration pins choose the input form and the line code. AMI and B8ZS decoding share one polarity tracker and one eight-deep delay line. CMI symbols are first turned into signed marks and then pass through that same path. In NRZ mode the serial bits go through the delay line with no polarity decoding at all.

The input side is a qualified stream (`in_valid`) with no ready signal, because a line cannot be paused. The output side is a one-cycle `out_valid` pulse per decoded bit, also with no ready, so the consumer has to take every pulse. Each released bit carries a violation flag. That flag also drives a saturating counter, which can be cleared, or snapshotted and cleared in one atomic step.

Top module: `t1rx_line_decoder`

## Requirements
- R1: After reset `out_valid`, `out_data`, `out_cv`, `cnt_value` and `cnt_snapshot` are all zero.
- R2: With `cfg_serial`=0 each `in_valid` cycle is one bit event. `in_rail_p` alone is a positive mark, `in_rail_n` alone is a negative mark, and neither is a space. `out_data`=1 for a mark. The bit presented at event k appears with the `out_valid` pulse that follows event k+8. Events 0..7 after reset release zeros.
- R3: When decoding is active (any mode except NRZ), a mark whose polarity equals that of the previous mark since reset is released with `out_cv`=1. The first mark after reset is never flagged.
- R4: Both rails high in one bit event gives a mark that keeps the previous mark polarity and raises exactly one violation.
- R5: With `cfg_b8zs`=1, eight bits in the form 0,0,0,V,B,0,V,B are released as eight zeros with no violation. Here V repeats the polarity of the mark before it, and B has the opposite polarity to the V before it. A violation outside such a pattern is still flagged.
- R6: With `cfg_serial`=1 and `cfg_cmi`=1, two `in_valid` strobes make one bit, first half first. 01 is a space, 11 is a positive mark, 00 is a negative mark, and 10 is a space with no violation and no correction. The marks then follow R3 and R5 according to `cfg_b8zs`.
- R7: With `cfg_serial`=1 and `cfg_cmi`=0, each strobe's `in_ser` value is released 8 events later as `out_data`. `out_cv` stays 0 and the counter does not move.
- R8: `cnt_value` rises by one on the same edge that releases a bit with `out_cv`=1. It holds at 65535.
- R9: `cnt_clr` zeroes `cnt_value` on the next edge and overrides counting and snapshot.
- R10: `cnt_snap` copies the pre-edge `cnt_value` into `cnt_snapshot`. The count restarts at 0, or at 1 if a violation is released on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_serial | input | 1 | 0: dual-rail input, 1: serial input |
| cfg_cmi | input | 1 | Serial input only: 1 = CMI half-bit symbols, 0 = NRZ |
| cfg_b8zs | input | 1 | 1: remove B8ZS substitutions, 0: plain AMI |
| in_valid | input | 1 | Qualifies one bit (dual-rail, NRZ) or one half-bit (CMI) |
| in_rail_p | input | 1 | Positive pulse indication |
| in_rail_n | input | 1 | Negative pulse indication |
| in_ser | input | 1 | Serial line input |
| cnt_clr | input | 1 | Synchronous clear of the violation count |
| cnt_snap | input | 1 | Snapshot the count and restart it |
| out_valid | output | 1 | One-cycle pulse per decoded bit |
| out_data | output | 1 | Decoded NRZ bit |
| out_cv | output | 1 | Violation flag of the released bit |
| cnt_value | output | 16 | Live violation count |
| cnt_snapshot | output | 16 | Count captured by the last snapshot |

## Verification
The bench goes after the B8ZS window. Its directed runs of sixteen zeros make two back-to-back substitutions, and a lone same-polarity mark follows them. A decoder that matched the wrong window would leak V/B marks into the data, and one that over-matched would hide the lone violation. The same B8ZS line is also fed in AMI mode, where every V must be counted. Other targets are the CMI invalid symbol, which must decode as a quiet zero; NRZ streams, which must never raise a violation; both-rails pulses, which must count once and keep the polarity; and a run of more than 65535 violations, where a counter that wrapped would read a small value.

// File: rtl/t1rx_pkg.sv
package t1rx_pkg;
  // One bit held in the decode delay line.
  typedef struct packed {
    logic mark;  // decoded bit value
    logic bpv;   // same-polarity violation (candidate V of a substitution)
    logic cv;    // counted code violation
  } slot_t;

  localparam int SUB_LEN = 8;  // length of the zero-substitution window
endpackage

// File: rtl/t1rx_sym_front.sv
// Turns dual-rail pulses, CMI half-bit pairs or NRZ bits into bit events
// carrying a mark, its polarity (0 positive, 1 negative) and a both-rails flag.
module t1rx_sym_front (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_serial,
  input  logic cfg_cmi,
  input  logic in_valid,
  input  logic in_rail_p,
  input  logic in_rail_n,
  input  logic in_ser,
  output logic ev,
  output logic ev_mark,
  output logic ev_pol,
  output logic ev_both
);
  logic cmi_mode;
  logic half_phase;  // 1: first half already captured
  logic half_q;

  assign cmi_mode = cfg_serial & cfg_cmi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_phase <= 1'b0;
      half_q     <= 1'b0;
    end else if (!cmi_mode) begin
      half_phase <= 1'b0;
    end else if (in_valid) begin
      half_phase <= ~half_phase;
      if (!half_phase) half_q <= in_ser;
    end
  end

  always_comb begin
    ev      = 1'b0;
    ev_mark = 1'b0;
    ev_pol  = 1'b0;
    ev_both = 1'b0;
    if (!cfg_serial) begin
      ev      = in_valid;
      ev_mark = in_rail_p | in_rail_n;
      ev_pol  = in_rail_n & ~in_rail_p;
      ev_both = in_rail_p & in_rail_n;
    end else if (!cfg_cmi) begin
      ev      = in_valid;
      ev_mark = in_ser;
    end else begin
      ev = in_valid & half_phase;
      unique case ({half_q, in_ser})
        2'b11:   begin ev_mark = 1'b1; ev_pol = 1'b0; end
        2'b00:   begin ev_mark = 1'b1; ev_pol = 1'b1; end
        default: begin ev_mark = 1'b0; ev_pol = 1'b0; end  // 01 space, 10 not corrected
      endcase
    end
  end
endmodule

// File: rtl/t1rx_bpv_line.sv
// Polarity tracking, violation marking, substitution removal and the fixed
// delay line. DEPTH must be at least SUB_LEN.
module t1rx_bpv_line
  import t1rx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic decode_en,
  input  logic b8zs_en,
  input  logic ev,
  input  logic ev_mark,
  input  logic ev_pol,
  input  logic ev_both,
  output logic out_valid,
  output logic out_data,
  output logic out_cv,
  output logic cv_release
);
  slot_t line_q [DEPTH];
  slot_t line_d [DEPTH];
  slot_t fresh;
  logic  have_mark;
  logic  last_pol;
  logic  pol_eff;
  logic  match;

  assign pol_eff = ev_both ? last_pol : ev_pol;

  always_comb begin
    fresh      = '0;
    fresh.mark = ev_mark;
    if (decode_en) begin
      fresh.bpv = ev_mark & ~ev_both & have_mark & (ev_pol == last_pol);
      fresh.cv  = fresh.bpv | ev_both;
    end
  end

  // Window oldest..newest = line_q[6] .. line_q[0], fresh
  always_comb begin
    match = b8zs_en & decode_en
          & ~line_q[SUB_LEN-2].mark & ~line_q[SUB_LEN-3].mark & ~line_q[SUB_LEN-4].mark
          & line_q[SUB_LEN-5].bpv
          & line_q[SUB_LEN-6].mark & ~line_q[SUB_LEN-6].cv
          & ~line_q[SUB_LEN-7].mark
          & line_q[SUB_LEN-8].bpv
          & fresh.mark & ~fresh.cv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_mark <= 1'b0;
      last_pol  <= 1'b0;
    end else if (ev && decode_en && ev_mark) begin
      have_mark <= 1'b1;
      last_pol  <= pol_eff;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_tap
    if (i == 0) begin : g_head
      assign line_d[i] = match ? '0 : fresh;
    end else if (i < SUB_LEN) begin : g_win
      assign line_d[i] = match ? '0 : line_q[i-1];
    end else begin : g_tail
      assign line_d[i] = line_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  line_q[i] <= '0;
      else if (ev) line_q[i] <= line_d[i];
    end
  end

  assign cv_release = ev & line_q[DEPTH-1].cv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= 1'b0;
      out_cv    <= 1'b0;
    end else begin
      out_valid <= ev;
      out_data  <= ev & line_q[DEPTH-1].mark;
      out_cv    <= cv_release;
    end
  end
endmodule

// File: rtl/t1rx_cv_count.sv
// Saturating violation counter with clear and snapshot-and-restart.
module t1rx_cv_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  input  logic             snap,
  output logic [CNT_W-1:0] value,
  output logic [CNT_W-1:0] snapshot
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value    <= '0;
      snapshot <= '0;
    end else if (clr) begin
      value <= '0;
    end else if (snap) begin
      snapshot <= value;
      value    <= inc ? ONE : '0;
    end else if (inc && value != CMAX) begin
      value <= value + ONE;
    end
  end
endmodule

// File: rtl/t1rx_line_decoder.sv
module t1rx_line_decoder #(
  parameter int LINE_DEPTH = 8,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_serial,
  input  logic             cfg_cmi,
  input  logic             cfg_b8zs,
  input  logic             in_valid,
  input  logic             in_rail_p,
  input  logic             in_rail_n,
  input  logic             in_ser,
  input  logic             cnt_clr,
  input  logic             cnt_snap,
  output logic             out_valid,
  output logic             out_data,
  output logic             out_cv,
  output logic [CNT_W-1:0] cnt_value,
  output logic [CNT_W-1:0] cnt_snapshot
);
  logic ev, ev_mark, ev_pol, ev_both;
  logic decode_en;
  logic cv_release;

  assign decode_en = ~(cfg_serial & ~cfg_cmi);

  t1rx_sym_front u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_serial(cfg_serial),
    .cfg_cmi   (cfg_cmi),
    .in_valid  (in_valid),
    .in_rail_p (in_rail_p),
    .in_rail_n (in_rail_n),
    .in_ser    (in_ser),
    .ev        (ev),
    .ev_mark   (ev_mark),
    .ev_pol    (ev_pol),
    .ev_both   (ev_both)
  );

  t1rx_bpv_line #(.DEPTH(LINE_DEPTH)) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .decode_en (decode_en),
    .b8zs_en   (cfg_b8zs),
    .ev        (ev),
    .ev_mark   (ev_mark),
    .ev_pol    (ev_pol),
    .ev_both   (ev_both),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_cv    (out_cv),
    .cv_release(cv_release)
  );

  t1rx_cv_count #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (cv_release),
    .clr     (cnt_clr),
    .snap    (cnt_snap),
    .value   (cnt_value),
    .snapshot(cnt_snapshot)
  );
endmodule

// File: rtl/t1rx_line_decoder_chk.sv
module t1rx_line_decoder_chk #(
  parameter int LINE_DEPTH = 8,
  parameter int CNT_W      = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_serial,
  input logic             cfg_cmi,
  input logic             in_valid,
  input logic             cnt_clr,
  input logic             cnt_snap,
  input logic             out_valid,
  input logic             out_data,
  input logic             out_cv,
  input logic [CNT_W-1:0] cnt_value,
  input logic [CNT_W-1:0] cnt_snapshot
);
  localparam int              NW   = $clog2(LINE_DEPTH + 2) + 1;
  localparam logic [NW-1:0]   NLIM = NW'(LINE_DEPTH + 1);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic          nrz_mode, cmi_mode;
  logic [NW-1:0] nrz_seen;

  assign nrz_mode = cfg_serial & ~cfg_cmi;
  assign cmi_mode = cfg_serial & cfg_cmi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          nrz_seen <= '0;
    else if (!nrz_mode)                  nrz_seen <= '0;
    else if (in_valid && nrz_seen < NLIM) nrz_seen <= nrz_seen + 1'b1;
  end

  // R3
  cv_on_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_cv |-> (out_data && out_valid));

  // R7
  nrz_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nrz_mode && nrz_seen >= NLIM) |-> !out_cv);

  // R6
  cmi_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmi_mode && $past(cmi_mode) && $past(cmi_mode, 2) && out_valid) |-> !$past(out_valid));

  // R8
  cnt_hold_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_value == CMAX && !cnt_clr && !cnt_snap) |=> cnt_value == CMAX);

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && !cnt_snap) |=> (cnt_value == $past(cnt_value) || cnt_value == $past(cnt_value) + ONE));

  // R9
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> cnt_value == '0);

  // R10
  cnt_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_snap && !cnt_clr) |=> (cnt_snapshot == $past(cnt_value) && cnt_value <= ONE));
endmodule

bind t1rx_line_decoder t1rx_line_decoder_chk #(
  .LINE_DEPTH(LINE_DEPTH),
  .CNT_W     (CNT_W)
) u_chk (.*);

// File: tb/t1rx_line_decoder_bench.sv
module t1rx_line_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_serial, cfg_cmi, cfg_b8zs;
  logic        in_valid, in_rail_p, in_rail_n, in_ser;
  logic        cnt_clr, cnt_snap;
  logic        out_valid, out_data, out_cv;
  logic [15:0] cnt_value, cnt_snapshot;

  always #10 clk = ~clk;

  t1rx_line_decoder u_t1rx_line_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_serial(cfg_serial), .cfg_cmi(cfg_cmi),
    .cfg_b8zs(cfg_b8zs), .in_valid(in_valid), .in_rail_p(in_rail_p),
    .in_rail_n(in_rail_n), .in_ser(in_ser), .cnt_clr(cnt_clr), .cnt_snap(cnt_snap),
    .out_valid(out_valid), .out_data(out_data), .out_cv(out_cv),
    .cnt_value(cnt_value), .cnt_snapshot(cnt_snapshot)
  );

  int n_chk = 0;
  int n_fail = 0;
  int dat  [0:1023];
  int sym  [0:1023];  // 0 space, +1/-1 mark, 2 both rails, 3 CMI invalid
  int edat [0:1023];
  int ecv  [0:1023];
  int ev_n;
  int enc_last;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic do_reset(logic s, logic c, logic b);
    rst_n = 1'b0; cfg_serial = s; cfg_cmi = c; cfg_b8zs = b;
    in_valid = 0; in_rail_p = 0; in_rail_n = 0; in_ser = 0;
    cnt_clr = 0; cnt_snap = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ev_n = 0;
    for (int i = 0; i < 1024; i++) begin sym[i] = 0; edat[i] = 0; ecv[i] = 0; end
  endtask

  task automatic check_out(string req);
    int xd, xc;
    xd = (ev_n >= 8) ? edat[ev_n-8] : 0;
    xc = (ev_n >= 8) ? ecv[ev_n-8] : 0;
    chk({req, " valid"}, int'(out_valid), 1);
    chk({req, " data"}, int'(out_data), xd);
    chk({req, " cv"}, int'(out_cv), xc);
    ev_n++;
  endtask

  task automatic dual_bit(int s, string req);
    in_valid = 1;
    in_rail_p = (s == 1 || s == 2);
    in_rail_n = (s == -1 || s == 2);
    @(negedge clk);
    in_valid = 0;
    check_out(req);
  endtask

  task automatic ser_half(logic d);
    in_valid = 1; in_ser = d;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic cmi_bit(int s, string req);
    logic a, b;
    case (s)
      1:       begin a = 1; b = 1; end
      -1:      begin a = 0; b = 0; end
      3:       begin a = 1; b = 0; end
      default: begin a = 0; b = 1; end
    endcase
    ser_half(a);
    chk({req, " half idle"}, int'(out_valid), 0);
    ser_half(b);
    check_out(req);
  endtask

  task automatic gen_data(int n, int dens);
    for (int i = 0; i < n; i++) dat[i] = (($urandom % 100) < dens) ? 1 : 0;
    dat[0] = 1;
  endtask

  // Line encoder: AMI, optionally with the B8ZS substitution 000VB0VB.
  task automatic encode(int n, bit b8);
    int i, last;
    bit run;
    last = -1;
    i = 0;
    while (i < n) begin
      run = b8 && (i + 8 <= n);
      for (int k = 0; k < 8 && run; k++) if (dat[i+k] != 0) run = 0;
      if (run) begin
        sym[i] = 0; sym[i+1] = 0; sym[i+2] = 0; sym[i+3] = last;
        sym[i+4] = -last; sym[i+5] = 0; sym[i+6] = -last; sym[i+7] = last;
        i += 8;
      end else begin
        if (dat[i] != 0) begin last = -last; sym[i] = last; end
        else sym[i] = 0;
        i++;
      end
    end
    enc_last = last;
  endtask

  // Expected AMI decode of a symbol sequence.
  task automatic ami_expect(int n);
    int last;
    last = 0;
    for (int i = 0; i < n; i++) begin
      if (sym[i] == 2) begin edat[i] = 1; ecv[i] = 1; end
      else if (sym[i] == 1 || sym[i] == -1) begin
        edat[i] = 1;
        ecv[i]  = (last != 0 && sym[i] == last) ? 1 : 0;
        last    = sym[i];
      end else begin edat[i] = 0; ecv[i] = 0; end
    end
  endtask

  function automatic int sum_cv(int n);
    int s = 0;
    for (int i = 0; i < n; i++) s += ecv[i];
    return s;
  endfunction

  task automatic flush_tail(int n);
    for (int i = n; i < n + 8; i++) begin sym[i] = 0; edat[i] = 0; ecv[i] = 0; end
  endtask

  task automatic run_seq(int n, int how, string req);
    for (int i = 0; i < n; i++) begin
      if (how == 0)      dual_bit(sym[i], req);
      else if (how == 1) cmi_bit(sym[i], req);
      else begin ser_half(sym[i][0]); check_out(req); end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int k;
    void'($urandom(32'd24601));

    // R1 reset state
    do_reset(0, 0, 0);
    @(negedge clk);
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 data", int'(out_data), 0);
    chk("R1 cv", int'(out_cv), 0);
    chk("R1 count", int'(cnt_value), 0);
    chk("R1 snapshot", int'(cnt_snapshot), 0);

    // R2/R3/R4: AMI dual rail, then a repeated polarity and a both-rails pulse
    gen_data(200, 50);
    encode(200, 0);
    sym[200] = enc_last; sym[201] = enc_last; sym[202] = 2;
    ami_expect(203);
    flush_tail(203);
    run_seq(211, 0, "R2 R3 R4 ami");
    k = sum_cv(211);
    chk("R8 ami count", int'(cnt_value), k);

    // R10 snapshot then R9 clear
    cnt_snap = 1; @(negedge clk); cnt_snap = 0;
    chk("R10 snapshot", int'(cnt_snapshot), k);
    chk("R10 restart", int'(cnt_value), 0);
    ev_n = 0;
    for (int i = 0; i < 16; i++) begin sym[i] = (i < 3) ? 2 : 0; edat[i] = (i < 3); ecv[i] = (i < 3); end
    run_seq(16, 0, "R4 both");
    chk("R8 both count", int'(cnt_value), 3);
    cnt_clr = 1; cnt_snap = 1; @(negedge clk); cnt_clr = 0; cnt_snap = 0;
    chk("R9 clear", int'(cnt_value), 0);
    chk("R9 snapshot kept", int'(cnt_snapshot), k);

    // R5: B8ZS with directed double substitution and a lone violation
    do_reset(0, 0, 1);
    gen_data(240, 30);
    dat[39] = 1; for (int i = 40; i < 56; i++) dat[i] = 0; dat[56] = 1;
    dat[119] = 1; for (int i = 120; i < 128; i++) dat[i] = 0; dat[128] = 1;
    encode(240, 1);
    for (int i = 0; i < 240; i++) begin edat[i] = dat[i]; ecv[i] = 0; end
    sym[240] = enc_last; edat[240] = 1; ecv[240] = 1;
    flush_tail(241);
    run_seq(249, 0, "R5 b8zs");
    chk("R5 count", int'(cnt_value), 1);

    // R3: the same kind of line decoded as plain AMI counts every V
    do_reset(0, 0, 0);
    gen_data(200, 30);
    dat[59] = 1; for (int i = 60; i < 76; i++) dat[i] = 0; dat[76] = 1;
    encode(200, 1);
    ami_expect(200);
    flush_tail(200);
    run_seq(208, 0, "R3 ami on b8zs");
    chk("R3 count", int'(cnt_value), sum_cv(208));

    // R6: CMI with B8ZS post-processing and an invalid symbol
    do_reset(1, 1, 1);
    gen_data(200, 30);
    dat[29] = 1; for (int i = 30; i < 38; i++) dat[i] = 0; dat[38] = 1;
    encode(200, 1);
    for (int i = 0; i < 200; i++) begin edat[i] = dat[i]; ecv[i] = 0; end
    sym[200] = 3; edat[200] = 0; ecv[200] = 0;
    flush_tail(201);
    run_seq(209, 1, "R6 cmi b8zs");
    chk("R6 count", int'(cnt_value), 0);

    // R6: CMI with AMI post-processing and a repeated polarity
    do_reset(1, 1, 0);
    gen_data(120, 50);
    encode(120, 0);
    sym[120] = enc_last;
    ami_expect(121);
    flush_tail(121);
    run_seq(129, 1, "R6 cmi ami");
    chk("R6 ami count", int'(cnt_value), 1);

    // R7: NRZ bypass
    do_reset(1, 0, 1);
    gen_data(200, 50);
    for (int i = 0; i < 200; i++) begin sym[i] = dat[i]; edat[i] = dat[i]; ecv[i] = 0; end
    flush_tail(200);
    run_seq(208, 2, "R7 nrz");
    chk("R7 count", int'(cnt_value), 0);

    // R8: saturation
    do_reset(0, 0, 0);
    in_valid = 1; in_rail_p = 1; in_rail_n = 1;
    repeat (65545) @(negedge clk);
    in_rail_p = 0; in_rail_n = 0;
    repeat (8) @(negedge clk);
    in_valid = 0;
    @(negedge clk);
    chk("R8 saturate", int'(cnt_value), 65535);
    cnt_snap = 1; @(negedge clk); cnt_snap = 0;
    chk("R10 snapshot max", int'(cnt_snapshot), 65535);
    chk("R10 restart max", int'(cnt_value), 0);

    summary();
    $finish;
  end
endmodule